// File: doc/BRIEF.md
# Transmit Word-Sync Sequencer

This block decides, one character slot per clock, what a transmit lane puts on the wire ahead of the serializer. Each clock it takes a data byte and three control inputs, and produces one 10-bit line character together with the running disparity that follows that character.

In encoded mode, each slot carries one of four things:
- a data character;
- the K28.5 comma used as the idle fill;
- one of twelve user special characters;
- a word-sync burst.

A word-sync burst is sixteen K28.5 characters. Its second and fourth characters break the normal disparity alternation on purpose, so that a receiver can find a sync point in the stream. While a burst is running, every input is locked out. In bypass mode the inputs are packed into a raw 10-bit character and sent one clock earlier.

The serializer downstream takes one character every clock and cannot stall. For that reason there is no valid/ready handshake and no back-pressure: every clock consumes one input slot and produces one output slot.

`raw_mode` is a quasi-static configuration pin. Changing it in the middle of a stream may corrupt the characters in flight at the moment it changes.

Top module: `wsync_tx_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is `char_out`=0, `rd_pos`=0 (negative running disparity) and `sync_busy`=0. Any burst in progress is abandoned and does not resume after reset.
- R2: With `ctl_sel` low in encoded mode, `tx_byte` is sent as the standard 8b/10b data character Dx.y, where x=`tx_byte[4:0]` and y=`tx_byte[7:5]`. `kspec_en` has no effect on it. `char_out[0]` is the first transmitted bit (the a bit), up to `char_out[9]` (the j bit).
- R3: With `ctl_sel` high and `kspec_en` low, K28.5 is sent and `tx_byte` is ignored. The code is 10'h17C at negative running disparity and 10'h283 at positive running disparity.
- R4: With `ctl_sel` and `kspec_en` both high, `tx_byte` selects one of these special characters, in 8b/10b encoding:
  - K28.y, for bytes 8'h1C, 8'h3C, …, 8'hFC;
  - K23.7 (8'hF7), K27.7 (8'hFB), K29.7 (8'hFD) and K30.7 (8'hFE).
- R5: `rd_pos` gives the running disparity after the character currently on `char_out` (1 = positive). Every encoded character has 4, 5 or 6 ones, and its disparity updates `rd_pos` accordingly.
- R6: In encoded mode, inputs sampled at edge n appear on `char_out` after edge n+1. In bypass mode they appear after edge n.
- R7: In encoded mode, `sync_req` high at a sampling edge when no burst is running starts a 16-slot burst. `tx_byte`, `ctl_sel`, `kspec_en` and `sync_req` are ignored in that slot and in the 15 slots that follow.
- R8: Burst slot k (k=0..15) uses K28.5 at polarity s⊕f(k), where s is the running disparity before slot 0. The f values are 0,0,1,1 for k=0..3, and 1 for odd k and 0 for even k from k=4 on. This gives + + - - + - … from positive and the inverse from negative.
- R9: After the last burst character, `rd_pos` equals the running disparity that was in force before the burst.
- R10: If `sync_req` is high at the first sampling edge after a burst's lockout, a new burst follows with no gap.
- R11: `sync_busy` is high exactly while `char_out` carries a burst character.
- R12: In bypass mode (`raw_mode` high), `char_out` = {`sync_req`, `ctl_sel`, `tx_byte`}, no burst starts, `sync_busy` is 0 and `rd_pos` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_mode | input | 1 | High: bypass the encoder (quasi-static) |
| tx_byte | input | 8 | Data byte, special-character select, or raw bits 7:0 |
| ctl_sel | input | 1 | Control/data select; raw bit 8 in bypass |
| kspec_en | input | 1 | Static enable for user special characters |
| sync_req | input | 1 | Word-sync burst request; raw bit 9 in bypass |
| char_out | output | 10 | Line character, bit 0 sent first |
| rd_pos | output | 1 | Running disparity after `char_out` (1 = positive) |
| sync_busy | output | 1 | High while `char_out` carries a burst character |

## Verification
The bench provokes two functions in the same cycle:
- A new `sync_req` arriving exactly on the sampling edge where the previous burst's lockout ends, which forces a burst restart to compete with resumption of normal traffic. This is held high across two whole bursts.
- A sync request raised together with `ctl_sel`, `kspec_en` and a special byte, where the request must win.

A behavioural reference model, driven with the same stimulus, predicts `char_out`, `rd_pos` and `sync_busy` on every clock. The bench judges the disparity seam at each burst edge as well as the codes. It also starts bursts from both running disparities, and checks that a reset in the middle of a burst leaves no remnant.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  typedef enum logic [1:0] {
    SLOT_DATA  = 2'd0,
    SLOT_IDLE  = 2'd1,
    SLOT_KSPEC = 2'd2,
    SLOT_SYNC  = 2'd3
  } slot_kind_e;

  localparam logic [7:0] IDLE_BYTE = 8'hBC;   // K28.5 selector
  localparam logic [9:0] IDLE_NEG  = 10'h17C; // K28.5 at negative disparity, bit0 first
  localparam logic [9:0] IDLE_POS  = 10'h283; // K28.5 at positive disparity
endpackage

// File: rtl/wsync_slot_sel.sv
// Input stage: classifies each slot and runs the burst lockout counter.
module wsync_slot_sel
  import wsync_pkg::*;
#(
  parameter int unsigned BURST_LEN = 16,
  localparam int unsigned IDX_W = $clog2(BURST_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_mode,
  input  logic [7:0]       tx_byte,
  input  logic             ctl_sel,
  input  logic             kspec_en,
  input  logic             sync_req,
  output slot_kind_e       slot_kind,
  output logic [7:0]       slot_byte,
  output logic [IDX_W-1:0] slot_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

  logic [IDX_W-1:0] lock_cnt;
  logic             locked;

  assign locked = (lock_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_cnt  <= '0;
      slot_kind <= SLOT_DATA;
      slot_byte <= '0;
      slot_idx  <= '0;
    end else if (raw_mode) begin
      lock_cnt  <= '0;
      slot_kind <= SLOT_DATA;
      slot_byte <= '0;
      slot_idx  <= '0;
    end else if (locked) begin
      slot_kind <= SLOT_SYNC;
      slot_idx  <= lock_cnt;
      lock_cnt  <= (lock_cnt == LAST_IDX) ? '0 : lock_cnt + 1'b1;
    end else if (sync_req) begin
      slot_kind <= SLOT_SYNC;
      slot_idx  <= '0;
      lock_cnt  <= IDX_W'(1);
    end else if (!ctl_sel) begin
      slot_kind <= SLOT_DATA;
      slot_byte <= tx_byte;
    end else if (!kspec_en) begin
      slot_kind <= SLOT_IDLE;
    end else begin
      slot_kind <= SLOT_KSPEC;
      slot_byte <= tx_byte;
    end
  end

  AST_LOCK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_mode && slot_kind == SLOT_SYNC && slot_idx != LAST_IDX)
      |=> (slot_kind == SLOT_SYNC && slot_idx == $past(slot_idx) + 1'b1)); // R7

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_mode && sync_req && slot_kind == SLOT_SYNC && slot_idx == LAST_IDX)
      |=> (slot_kind == SLOT_SYNC && slot_idx == '0)); // R10
endmodule

// File: rtl/wsync_enc8b10b.sv
// Combinational 8b/10b encoder; code bit 0 is the first transmitted (a) bit.
module wsync_enc8b10b (
  input  logic [7:0] byte_in,
  input  logic       is_k,
  input  logic       rd_in,
  output logic [9:0] code,
  output logic       rd_out
);
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  logic [4:0] x;
  logic [2:0] y;
  logic [5:0] c6n, c6;
  logic [3:0] c4n, c4;
  logic       un6, un4, rd_mid, alt7, kflip;
  logic [9:0] fwd;

  always_comb begin
    x      = byte_in[4:0];
    y      = byte_in[7:5];
    c6n    = (is_k && x == 5'd28) ? 6'b001111 : six_neg(x);
    un6    = ($countones(c6n) != 3);
    c6     = (rd_in && (un6 || x == 5'd7)) ? ~c6n : c6n;
    rd_mid = rd_in ^ un6;
    alt7   = is_k
           || (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20))
           || ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14));
    case (y)
      3'd0:    c4n = 4'b1011;
      3'd1:    c4n = 4'b1001;
      3'd2:    c4n = 4'b0101;
      3'd3:    c4n = 4'b1100;
      3'd4:    c4n = 4'b1101;
      3'd5:    c4n = 4'b1010;
      3'd6:    c4n = 4'b0110;
      default: c4n = alt7 ? 4'b0111 : 4'b1110;
    endcase
    un4    = ($countones(c4n) != 2);
    kflip  = is_k && !rd_mid && (y == 3'd1 || y == 3'd2 || y == 3'd5 || y == 3'd6);
    if (rd_mid && (un4 || y == 3'd3)) c4 = ~c4n;
    else if (kflip)                   c4 = ~c4n;
    else                              c4 = c4n;
    rd_out = rd_mid ^ un4;
    fwd    = {c6, c4};
    for (int i = 0; i < 10; i++) code[i] = fwd[9-i];
  end
endmodule

// File: rtl/wsync_tx_sequencer.sv
// Top: slot selection, encoding and the output/disparity register.
module wsync_tx_sequencer
  import wsync_pkg::*;
#(
  parameter int unsigned BURST_LEN = 16  // even, at least 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_mode,
  input  logic [7:0] tx_byte,
  input  logic       ctl_sel,
  input  logic       kspec_en,
  input  logic       sync_req,
  output logic [9:0] char_out,
  output logic       rd_pos,
  output logic       sync_busy
);
  localparam int unsigned IDX_W = $clog2(BURST_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

  slot_kind_e       slot_kind;
  logic [7:0]       slot_byte;
  logic [IDX_W-1:0] slot_idx;
  logic [7:0]       enc_byte;
  logic             enc_k;
  logic [9:0]       enc_code;
  logic             enc_rd;
  logic             base_q;
  logic             sync_pol;

  // Polarity offset of burst slot i relative to the starting disparity.
  function automatic logic burst_flip(input logic [IDX_W-1:0] i);
    int unsigned iv;
    iv = 32'(i);
    return (iv < 4) ? (iv >= 2) : i[0];
  endfunction

  wsync_slot_sel #(.BURST_LEN(BURST_LEN)) u_sel (
    .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .tx_byte(tx_byte),
    .ctl_sel(ctl_sel), .kspec_en(kspec_en), .sync_req(sync_req),
    .slot_kind(slot_kind), .slot_byte(slot_byte), .slot_idx(slot_idx)
  );

  assign enc_byte = (slot_kind == SLOT_IDLE) ? IDLE_BYTE : slot_byte;
  assign enc_k    = (slot_kind != SLOT_DATA);

  wsync_enc8b10b u_enc (
    .byte_in(enc_byte), .is_k(enc_k), .rd_in(rd_pos),
    .code(enc_code), .rd_out(enc_rd)
  );

  assign sync_pol = ((slot_idx == '0) ? rd_pos : base_q) ^ burst_flip(slot_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      char_out  <= '0;
      rd_pos    <= 1'b0;
      sync_busy <= 1'b0;
      base_q    <= 1'b0;
    end else if (raw_mode) begin
      char_out  <= {sync_req, ctl_sel, tx_byte};
      sync_busy <= 1'b0;
    end else if (slot_kind == SLOT_SYNC) begin
      char_out  <= sync_pol ? IDLE_POS : IDLE_NEG;
      rd_pos    <= ~sync_pol;
      sync_busy <= 1'b1;
      if (slot_idx == '0) base_q <= rd_pos;
    end else begin
      char_out  <= enc_code;
      rd_pos    <= enc_rd;
      sync_busy <= 1'b0;
    end
  end

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_mode && slot_kind == SLOT_IDLE)
      |=> ((char_out == IDLE_NEG && rd_pos) || (char_out == IDLE_POS && !rd_pos))); // R3

  AST_ONES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_mode && slot_kind != SLOT_SYNC)
      |-> ($countones(enc_code) >= 4 && $countones(enc_code) <= 6)); // R5

  AST_RD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_mode && slot_kind != SLOT_SYNC)
      |-> (($countones(enc_code) == 5) == (enc_rd == rd_pos))); // R5

  AST_BURST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_mode && slot_kind == SLOT_SYNC && slot_idx == LAST_IDX)
      |=> (rd_pos == base_q)); // R9

  AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_busy |-> (char_out == IDLE_NEG || char_out == IDLE_POS)); // R11

  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    raw_mode |=> (!sync_busy && $stable(rd_pos))); // R12
endmodule

// File: tb/wsync_tx_sequencer_tb.sv
module wsync_tx_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] REL = 16'hAAAC; // burst polarity offsets, bit k = slot k

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw_mode = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       ctl_sel = 1'b0;
  logic       kspec_en = 1'b0;
  logic       sync_req = 1'b0;
  logic [9:0] char_out;
  logic       rd_pos;
  logic       sync_busy;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsync_tx_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .tx_byte(tx_byte),
    .ctl_sel(ctl_sel), .kspec_en(kspec_en), .sync_req(sync_req),
    .char_out(char_out), .rd_pos(rd_pos), .sync_busy(sync_busy)
  );

  logic [5:0] SIX [0:31];
  logic [3:0] FOUR [0:7];

  // reference model state
  int         m_kind, m_idx, m_left;
  logic [7:0] m_byte;
  logic       m_rd, m_base, m_busy;
  logic [9:0] m_out;

  function automatic logic [10:0] ref_enc(logic [7:0] b, logic k, logic rd);
    int x, y;
    logic [5:0] s;
    logic [3:0] f;
    logic r, r2;
    logic [9:0] w, c;
    x = int'(b[4:0]);
    y = int'(b[7:5]);
    s = (k && x == 28) ? 6'b001111 : SIX[x];
    r = rd ^ ($countones(s) != 3);
    if (rd && ($countones(s) != 3 || x == 7)) s = ~s;
    f = FOUR[y];
    if (y == 7 && (k || (!r && (x == 17 || x == 18 || x == 20)) ||
                   (r && (x == 11 || x == 13 || x == 14)))) f = 4'b0111;
    if (k && (y == 1 || y == 2 || y == 5 || y == 6)) f = r ? f : ~f;
    else if (r && ($countones(f) != 2 || y == 3)) f = ~f;
    r2 = r ^ ($countones(f) != 2);
    w = {s, f};
    for (int i = 0; i < 10; i++) c[i] = w[9-i];
    return {r2, c};
  endfunction

  task automatic model_update(logic [7:0] b, logic cd, logic k, logic ws, logic raw, logic rn);
    logic [10:0] e;
    logic pol;
    if (!rn) begin
      m_kind = 0; m_byte = 8'h00; m_idx = 0; m_left = 0;
      m_rd = 1'b0; m_base = 1'b0; m_out = 10'h000; m_busy = 1'b0;
      return;
    end
    if (raw) begin
      m_out = {ws, cd, b}; m_busy = 1'b0;
    end else if (m_kind == 3) begin
      if (m_idx == 0) m_base = m_rd;
      pol = m_base ^ REL[m_idx];
      m_out = pol ? 10'h283 : 10'h17C;
      m_rd = ~pol; m_busy = 1'b1;
    end else begin
      e = ref_enc((m_kind == 1) ? 8'hBC : m_byte, m_kind != 0, m_rd);
      m_out = e[9:0]; m_rd = e[10]; m_busy = 1'b0;
    end
    if (raw) begin
      m_kind = 0; m_byte = 8'h00; m_left = 0;
    end else if (m_left > 0) begin
      m_kind = 3; m_idx = 16 - m_left; m_left--;
    end else if (ws) begin
      m_kind = 3; m_idx = 0; m_left = 15;
    end else if (!cd) begin
      m_kind = 0; m_byte = b;
    end else if (!k) begin
      m_kind = 1;
    end else begin
      m_kind = 2; m_byte = b;
    end
  endtask

  task automatic check(bit ok, string tg, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tg, what, act, exp);
    end
  endtask

  task automatic step(logic [7:0] b, logic cd, logic k, logic ws, logic raw, logic rn, string tg);
    @(negedge clk);
    tx_byte = b; ctl_sel = cd; kspec_en = k; sync_req = ws; raw_mode = raw; rst_n = rn;
    @(posedge clk);
    #1;
    model_update(b, cd, k, ws, raw, rn);
    check(char_out == m_out && rd_pos == m_rd && sync_busy == m_busy, tg, "{char,rd,busy}",
          int'({char_out, rd_pos, sync_busy}), int'({m_out, m_rd, m_busy}));
  endtask

  int seed = 7;
  function automatic logic [7:0] nxt();
    seed = seed * 1103515245 + 12345;
    return seed[23:16];
  endfunction

  logic [7:0] kbytes [0:11];

  initial begin
    SIX = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001, 6'b011001, 6'b111000,
            6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100, 6'b011100, 6'b010111,
            6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
            6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
    FOUR = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    kbytes = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};

    // R1: reset state
    repeat (3) step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    check(char_out == 10'h000 && rd_pos == 1'b0 && sync_busy == 1'b0, "R1", "reset outputs",
          int'({char_out, rd_pos, sync_busy}), 0);

    // R3/R6: IDLE with a junk byte appears two edges after it is sampled
    step(8'h55, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3/R6");
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3/R6");
    check(char_out == 10'h17C && rd_pos == 1'b1, "R3 R6", "K28.5 at RD-", int'(char_out), 'h17C);
    step(8'hAA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    check(char_out == 10'h283 && rd_pos == 1'b0, "R3", "K28.5 at RD+", int'(char_out), 'h283);

    // R2/R5: data, kspec_en toggled as a don't-care
    for (int i = 0; i < 300; i++) step(nxt(), 1'b0, i[0], 1'b0, 1'b0, 1'b1, "R2/R5");
    for (int i = 0; i < 256; i++) step(8'(i), 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R2/R5");

    // R4: every special character, from both disparities
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < 12; i++) step(kbytes[i], 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R4/R5");

    // R7/R8/R9/R11: bursts with junk inputs in the lockout, from both disparities
    for (int rep = 0; rep < 2; rep++) begin
      step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3");          // flips disparity
      step(8'hFB, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R7");          // request beats special byte
      for (int i = 0; i < 15; i++) step(nxt(), i[0], 1'b1, i[1], 1'b0, 1'b1, "R7/R8/R11");
      for (int i = 0; i < 4; i++) step(nxt(), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8/R9/R11");
    end

    // R10: request held across two bursts, then released at a burst edge
    for (int i = 0; i < 32; i++) step(nxt(), 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
    for (int i = 0; i < 6; i++) step(nxt(), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10/R9");

    // R1: reset in the middle of a burst leaves no remnant
    step(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R1");
    for (int i = 0; i < 5; i++) step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 6; i++) step(nxt(), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1");

    // R12/R6: bypass, one edge of latency, sync_req is only bit 9
    step(8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R12");
    check(char_out == 10'h2A5 && sync_busy == 1'b0, "R12 R6", "raw char", int'(char_out), 'h2A5);
    for (int i = 0; i < 40; i++) step(nxt(), i[1], i[0], i[2], 1'b1, 1'b1, "R12");
    for (int i = 0; i < 20; i++) step(nxt(), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule